// File: doc/BRIEF.md
# Retire-Gated Miss Buffer

This block tracks outstanding line misses between a data cache and memory. Every load is compared by line address against all live entries at once. A load that matches an entry attaches to it, so each line is fetched only once. A load that matches nothing takes a free entry, and that entry raises one memory request. When the line returns, it is held privately in the entry. One response goes out that carries the full line and a bit mask of every requester that attached to the entry. A later load to a line that is already held gets the line on the next cycle.

The line is written into the cache array only after the miss's owning instruction has retired. The retire and squash inputs name the entry that the pipeline learned from `req_slot` when the miss was allocated. If the owner is squashed instead, the entry is released with no cache write, and the line is reported on the drop port so that it can go back toward memory. A squash that arrives while the fetch is still in flight marks the entry, and the later fill is absorbed. The entry count is a base count plus an extra allowance, because entries stay occupied until retirement. When every entry is busy, a new miss is held off by deasserting `req_ready`.

Top module: `retire_gated_miss_buffer`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `mem_req_valid`, `line_wr_valid` and `drop_valid` are all 0.
- R2: An accepted load whose line matches no live entry reports `req_hit`=0 and allocates an entry. Exactly one memory request follows, carrying that line address.
- R3: An accepted load to a line with a fetch outstanding reports `req_hit`=1 and the same `req_slot`, and no further memory request is made.
- R4: The cycle after a fill is taken, `resp_valid` is 1. `resp_data` equals the fill data, and bit k of `resp_ids` is set for every attached requester ID k.
- R5: An accepted load that matches an entry whose line has arrived gets, on the next cycle, a response with only its own ID bit set and the held line.
- R6: No cache write happens while the owner has not retired. After a retire of a filled entry, exactly one write of the full line to its address follows, and the entry is freed.
- R7: If the retire comes before the fill, the single cache write follows the fill.
- R8: A squash of a filled entry produces no cache write, pulses `drop_valid` with the line address on the next cycle, and frees the entry.
- R9: A squash while the fetch is in flight makes the later fill produce no response and no cache write, pulses `drop_valid` with the line address, and frees the entry.
- R10: With every entry live, a load matching none of them sees `req_ready`=0. A load matching a live entry is still accepted.
- R11: `req_ready` is 0 in any cycle in which `mem_fill_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load lookup request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | LINE_ADDR_W | Line address of the load |
| req_id | input | $clog2(NUM_IDS) | Requester ID |
| req_hit | output | 1 | Request matches a live entry |
| req_slot | output | SLOT_W | Entry matched or allocated |
| resp_valid | output | 1 | Response with line data |
| resp_ids | output | NUM_IDS | Mask of requesters served |
| resp_data | output | LINE_W | Full line |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory takes the fetch |
| mem_req_addr | output | LINE_ADDR_W | Line address to fetch |
| mem_req_slot | output | SLOT_W | Entry that issued the fetch |
| mem_fill_valid | input | 1 | Line returned from memory |
| mem_fill_slot | input | SLOT_W | Entry the fill belongs to |
| mem_fill_data | input | LINE_W | Returned line |
| retire_valid | input | 1 | Owner of an entry retired |
| retire_slot | input | SLOT_W | Entry whose owner retired |
| squash_valid | input | 1 | Owner of an entry squashed |
| squash_slot | input | SLOT_W | Entry whose owner was squashed |
| line_wr_valid | output | 1 | Cache array line write |
| line_wr_addr | output | LINE_ADDR_W | Line address written |
| line_wr_data | output | LINE_W | Line data written |
| drop_valid | output | 1 | Line discarded after squash |
| drop_addr | output | LINE_ADDR_W | Line address discarded |

## Verification
The embedded assertions rely on the environment to keep to these rules:
- A fill names only an entry whose fetch was handed to memory, and only once.
- Retire and squash name only live entries, and they never target the same entry.
- A squash of a filled entry and an absorbed fill never fall in the same cycle.

The bench keeps within these rules by acting as the memory itself. It fills only the slots it saw fetched, and it drives at most one retire, squash or fill per cycle, each aimed at an entry it allocated earlier.

// File: rtl/retire_gated_miss_buffer.sv
module retire_gated_miss_buffer #(
  parameter int BASE_ENTRIES  = 2,
  parameter int EXTRA_ENTRIES = 2,
  parameter int LINE_ADDR_W   = 26,
  parameter int LINE_W        = 64,
  parameter int NUM_IDS       = 8,
  localparam int ENTRIES = BASE_ENTRIES + EXTRA_ENTRIES,
  localparam int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int ID_W    = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [LINE_ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]        req_id,
  output logic                   req_hit,
  output logic [SLOT_W-1:0]      req_slot,
  output logic                   resp_valid,
  output logic [NUM_IDS-1:0]     resp_ids,
  output logic [LINE_W-1:0]      resp_data,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [LINE_ADDR_W-1:0] mem_req_addr,
  output logic [SLOT_W-1:0]      mem_req_slot,
  input  logic                   mem_fill_valid,
  input  logic [SLOT_W-1:0]      mem_fill_slot,
  input  logic [LINE_W-1:0]      mem_fill_data,
  input  logic                   retire_valid,
  input  logic [SLOT_W-1:0]      retire_slot,
  input  logic                   squash_valid,
  input  logic [SLOT_W-1:0]      squash_slot,
  output logic                   line_wr_valid,
  output logic [LINE_ADDR_W-1:0] line_wr_addr,
  output logic [LINE_W-1:0]      line_wr_data,
  output logic                   drop_valid,
  output logic [LINE_ADDR_W-1:0] drop_addr
);

  logic [ENTRIES-1:0]     live, fetched, filled, retired, killed;
  logic [LINE_ADDR_W-1:0] tag_q  [ENTRIES];
  logic [LINE_W-1:0]      line_q [ENTRIES];
  logic [NUM_IDS-1:0]     wait_q [ENTRIES];
  logic [ENTRIES-1:0]     match, pend, ready_wr;

  function automatic logic [SLOT_W-1:0] lowest(input logic [ENTRIES-1:0] v);
    lowest = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (v[i]) lowest = SLOT_W'(i);
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = live[g] & ~killed[g] & (tag_q[g] == req_addr);
  end

  assign pend     = live & ~fetched & ~killed;
  assign ready_wr = live & filled & retired & ~killed;

  logic [SLOT_W-1:0] hit_idx, free_idx, wr_idx;
  logic [NUM_IDS-1:0] id_bit;
  logic accept, handshake;

  assign hit_idx       = lowest(match);
  assign free_idx      = lowest(~live);
  assign wr_idx        = lowest(ready_wr);
  assign req_hit       = |match;
  assign req_slot      = req_hit ? hit_idx : free_idx;
  assign req_ready     = ~mem_fill_valid & (req_hit | ~&live);
  assign accept        = req_valid & req_ready;
  assign id_bit        = NUM_IDS'(1) << req_id;
  assign mem_req_valid = |pend;
  assign mem_req_slot  = lowest(pend);
  assign mem_req_addr  = tag_q[mem_req_slot];
  assign handshake     = mem_req_valid & mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0; fetched <= '0; filled <= '0; retired <= '0; killed <= '0;
      resp_valid <= 1'b0; line_wr_valid <= 1'b0; drop_valid <= 1'b0;
      resp_ids <= '0; resp_data <= '0; line_wr_addr <= '0; line_wr_data <= '0;
      drop_addr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0; line_q[i] <= '0; wait_q[i] <= '0;
      end
    end else begin
      resp_valid    <= 1'b0;
      line_wr_valid <= 1'b0;
      drop_valid    <= 1'b0;
      if (handshake) fetched[mem_req_slot] <= 1'b1;
      if (accept) begin
        if (req_hit) begin
          if (filled[hit_idx]) begin
            resp_valid <= 1'b1;
            resp_ids   <= id_bit;
            resp_data  <= line_q[hit_idx];
          end else begin
            wait_q[hit_idx] <= wait_q[hit_idx] | id_bit;
          end
        end else begin
          live[free_idx]    <= 1'b1;
          fetched[free_idx] <= 1'b0;
          filled[free_idx]  <= 1'b0;
          retired[free_idx] <= 1'b0;
          killed[free_idx]  <= 1'b0;
          tag_q[free_idx]   <= req_addr;
          wait_q[free_idx]  <= id_bit;
        end
      end
      if (mem_fill_valid && live[mem_fill_slot]) begin
        if (killed[mem_fill_slot]) begin
          live[mem_fill_slot] <= 1'b0;
          drop_valid <= 1'b1;
          drop_addr  <= tag_q[mem_fill_slot];
        end else begin
          filled[mem_fill_slot] <= 1'b1;
          line_q[mem_fill_slot] <= mem_fill_data;
          resp_valid <= 1'b1;
          resp_ids   <= wait_q[mem_fill_slot];
          resp_data  <= mem_fill_data;
        end
      end
      if (retire_valid && live[retire_slot]) retired[retire_slot] <= 1'b1;
      if (squash_valid && live[squash_slot] && !killed[squash_slot]) begin
        if (filled[squash_slot] || (mem_fill_valid && mem_fill_slot == squash_slot)) begin
          live[squash_slot] <= 1'b0;
          drop_valid <= 1'b1;
          drop_addr  <= tag_q[squash_slot];
        end else if (fetched[squash_slot] || (handshake && mem_req_slot == squash_slot)) begin
          killed[squash_slot] <= 1'b1;
        end else begin
          live[squash_slot] <= 1'b0;
        end
      end
      if (|ready_wr) begin
        line_wr_valid <= 1'b1;
        line_wr_addr  <= tag_q[wr_idx];
        line_wr_data  <= line_q[wr_idx];
        live[wr_idx]  <= 1'b0;
      end
    end
  end

  for (genvar a = 0; a < ENTRIES; a++) begin : g_pair
    for (genvar b = a + 1; b < ENTRIES; b++) begin : g_other
      a_r3_one_fetch_per_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(live[a] && live[b] && !killed[a] && !killed[b] && tag_q[a] == tag_q[b]));
    end
  end

  a_r11_no_accept_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fill_valid |-> !req_ready);

  a_r4_resp_has_requester: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_ids != '0);

  a_r2_fill_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fill_valid |-> live[mem_fill_slot] && fetched[mem_fill_slot] && !filled[mem_fill_slot]);

  a_r5_held_line_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_hit && filled[req_slot]) |=> resp_valid);

  a_r6_write_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr_valid |-> $past(retire_valid) || $past(|retired));

endmodule

// File: tb/sim_retire_gated_miss_buffer.sv
module sim_retire_gated_miss_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26, LW = 64, NI = 8, ENT = 4, SW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, mem_req_ready = 1, mem_fill_valid = 0, retire_valid = 0, squash_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_id = '0;
  logic [SW-1:0] mem_fill_slot = '0, retire_slot = '0, squash_slot = '0;
  logic [LW-1:0] mem_fill_data = '0;
  logic req_ready, req_hit, resp_valid, mem_req_valid, line_wr_valid, drop_valid;
  logic [SW-1:0] req_slot, mem_req_slot;
  logic [NI-1:0] resp_ids;
  logic [LW-1:0] resp_data, line_wr_data;
  logic [AW-1:0] mem_req_addr, line_wr_addr, drop_addr;

  int checks = 0, fails = 0;
  int n_fetch = 0, n_wr = 0, n_drop = 0, n_resp = 0;
  logic [AW-1:0] last_fetch, last_wr_addr, last_drop;
  logic [LW-1:0] last_wr_data;

  retire_gated_miss_buffer u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (mem_req_valid && mem_req_ready) begin n_fetch++; last_fetch = mem_req_addr; end
    if (line_wr_valid) begin n_wr++; last_wr_addr = line_wr_addr; last_wr_data = line_wr_data; end
    if (drop_valid) begin n_drop++; last_drop = drop_addr; end
    if (resp_valid) n_resp++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_req(input logic [AW-1:0] a, input logic [2:0] id,
                        output logic rdy, output logic hit, output logic [SW-1:0] slot);
    req_valid = 1; req_addr = a; req_id = id;
    @(negedge clk); rdy = req_ready; hit = req_hit; slot = req_slot;
    @(posedge clk); #1; req_valid = 0;
  endtask

  task automatic do_fill(input logic [SW-1:0] s, input logic [LW-1:0] d);
    mem_fill_valid = 1; mem_fill_slot = s; mem_fill_data = d;
    @(negedge clk); chk("R11 ready during fill", req_ready, 0);
    @(posedge clk); #1; mem_fill_valid = 0;
  endtask

  task automatic do_retire(input logic [SW-1:0] s);
    retire_valid = 1; retire_slot = s; tick(); retire_valid = 0;
  endtask

  task automatic do_squash(input logic [SW-1:0] s);
    squash_valid = 1; squash_slot = s; tick(); squash_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 line_wr_valid", line_wr_valid, 0);
    chk("R1 drop_valid", drop_valid, 0);
  endtask

  task automatic t_merge_fill_retire;
    logic r, h; logic [SW-1:0] s0, s1; int f0, w0;
    f0 = n_fetch; w0 = n_wr;
    do_req(26'h00A1, 3'd0, r, h, s0);
    chk("R2 first miss hit", h, 0);
    do_req(26'h00A1, 3'd3, r, h, s1);
    chk("R3 merge hit", h, 1);
    chk("R3 merge slot", s1, s0);
    tick(2);
    chk("R2 one fetch", n_fetch - f0, 1);
    chk("R2 fetch addr", last_fetch, 26'h00A1);
    do_fill(s0, 64'hDEAD_BEEF_0000_0001);
    chk("R4 resp_valid", resp_valid, 1);
    chk("R4 resp_ids", resp_ids, 8'b0000_1001);
    chk("R4 resp_data", resp_data, 64'hDEAD_BEEF_0000_0001);
    do_req(26'h00A1, 3'd5, r, h, s1);
    chk("R5 hit filled", h, 1);
    chk("R5 resp_valid", resp_valid, 1);
    chk("R5 resp_ids", resp_ids, 8'b0010_0000);
    chk("R5 resp_data", resp_data, 64'hDEAD_BEEF_0000_0001);
    tick(3);
    chk("R6 no write before retire", n_wr - w0, 0);
    do_retire(s0);
    tick(3);
    chk("R6 one write", n_wr - w0, 1);
    chk("R6 write addr", last_wr_addr, 26'h00A1);
    chk("R6 write data", last_wr_data, 64'hDEAD_BEEF_0000_0001);
    do_req(26'h00A1, 3'd1, r, h, s1);
    chk("R6 freed, new miss", h, 0);
    tick(2);
    // reuse this entry for the squash-after-fill case
    t_squash_filled(s1);
  endtask

  task automatic t_squash_filled(input logic [SW-1:0] s);
    int w0, d0;
    w0 = n_wr; d0 = n_drop;
    do_fill(s, 64'h1111_2222_3333_4444);
    do_squash(s);
    chk("R8 drop pulse", drop_valid, 1);
    chk("R8 drop addr", drop_addr, 26'h00A1);
    tick(3);
    chk("R8 no write", n_wr - w0, 0);
    chk("R8 one drop", n_drop - d0, 1);
  endtask

  task automatic t_squash_inflight;
    logic r, h; logic [SW-1:0] s, s1; int w0, d0, p0;
    w0 = n_wr; d0 = n_drop;
    do_req(26'h0B22, 3'd2, r, h, s);
    tick(2);
    do_squash(s);
    tick(2);
    p0 = n_resp;
    do_fill(s, 64'h5555_6666_7777_8888);
    chk("R9 no resp", resp_valid, 0);
    tick(3);
    chk("R9 no resp count", n_resp - p0, 0);
    chk("R9 no write", n_wr - w0, 0);
    chk("R9 one drop", n_drop - d0, 1);
    chk("R9 drop addr", last_drop, 26'h0B22);
    do_req(26'h0B22, 3'd4, r, h, s1);
    chk("R9 freed, new miss", h, 0);
    tick(2);
    t_retire_early(s1);
  endtask

  task automatic t_retire_early(input logic [SW-1:0] s);
    int w0;
    w0 = n_wr;
    do_retire(s);
    tick(3);
    chk("R7 no write before fill", n_wr - w0, 0);
    do_fill(s, 64'h9999_AAAA_BBBB_CCCC);
    chk("R7 resp on fill", resp_ids, 8'b0001_0000);
    tick(3);
    chk("R7 one write", n_wr - w0, 1);
    chk("R7 write addr", last_wr_addr, 26'h0B22);
    chk("R7 write data", last_wr_data, 64'h9999_AAAA_BBBB_CCCC);
  endtask

  task automatic t_full;
    logic r, h; logic [SW-1:0] s; int d0;
    d0 = n_drop;
    for (int i = 0; i < ENT; i++) do_req(AW'(26'h0C00 + i), 3'(i), r, h, s);
    tick(ENT + 2);
    do_req(26'h0DDD, 3'd6, r, h, s);
    chk("R10 new miss stalled", r, 0);
    do_req(26'h0C01, 3'd7, r, h, s);
    chk("R10 hit accepted", r, 1);
    chk("R10 hit flag", h, 1);
    for (int i = 0; i < ENT; i++) do_squash(SW'(i));
    for (int i = 0; i < ENT; i++) do_fill(SW'(i), 64'h0);
    tick(3);
    chk("R10 cleanup drops", n_drop - d0, ENT);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick();
    t_reset();
    t_merge_fill_retire();
    t_squash_inflight();
    t_full();
    tick(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule